// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset Pulse Output

This block is a watchdog for a small microcontroller core. It leaves reset switched off and stays off until software writes a two-byte key, 0x1E followed by 0xE1, to its restart address. From then on a counter advances once per machine cycle, marked by a one-clock strobe from the core's timing generator. Software cannot stop it. Writing the same key again while it runs clears the count and buys a fresh timeout.

If the counter runs past its all-ones value, the block drives a reset output high for a fixed number of oscillator clocks and returns to the disabled state. A mask bit in an auxiliary control register can suppress that pulse. The overflow still disables the timer when the pulse is masked. The block sees the core's register write bus and decodes only its own two addresses.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is disabled, `rst_out` is low and the pulse mask bit is 0, so the pulse is not masked.
- R2: A write of 0x1E to address 0xA6 arms the detector. A later write of 0xE1 to 0xA6 enables the timer with the count at zero. Writes to other addresses between the two do not disturb the key. Writing 0x1E again while armed keeps the detector armed.
- R3: A write to 0xA6 of any value other than 0x1E or 0xE1 while armed disarms the detector. A write of 0xE1 when the detector is not armed has no effect.
- R4: While enabled, the count rises by one on each clock with `mc_tick` high and holds otherwise. The overflow occurs on the 2^CNT_W-th tick after the count was last zeroed.
- R5: Once enabled, no register write stops the timer. Only an overflow or a hardware reset does.
- R6: A complete key written while the timer runs zeroes the count, so the next overflow comes 2^CNT_W ticks after that key.
- R7: An overflow drives `rst_out` high for exactly PULSE_LEN clocks, starting in the cycle after the overflowing tick.
- R8: Bit 3 of address 0x8E is the pulse mask. When it is 1, an overflow produces no pulse but still disables the timer. When it is 0, the pulse is produced.
- R9: After an overflow the timer is disabled and needs a new key. Writes to 0xA6 while `rst_out` is high are ignored.
- R10: A hardware reset while the timer runs disables it, so no overflow follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low hardware reset |
| mc_tick | input | 1 | One-clock machine-cycle strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rst_out | output | 1 | Active-high reset pulse on overflow |

## Verification
Assertions check the following on every clock:
- the timer turns on only in the cycle after a matched key, and turns off only after an overflow;
- the count steps by exactly one per tick, and a restart key zeroes it;
- a wrong byte disarms the detector;
- the pulse starts only from an unmasked overflow, never while the timer runs, and never after a masked overflow.

Some properties show only at the port, so the bench's scenarios must show them. These are the exact overflow distance in ticks, the pulse length, ordered and broken key sequences, keys written during the pulse, and the effect of a hardware reset mid-count.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   typedef enum logic [0:0] {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } key_state_e;
endpackage

// File: rtl/wdk_key_seq.sv
module wdk_key_seq #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
   parameter logic [DATA_W-1:0] KEY_FIRST = 8'h1E,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              block,
   output logic              key_hit
);
   import wdk_pkg::*;

   key_state_e state, state_nx;
   logic       sel;

   always_comb begin
      sel      = wr_en && (wr_addr == KEY_ADDR);
      key_hit  = sel && !block && (state == KEY_ARMED) && (wr_data == KEY_SECOND);
      state_nx = state;
      if (block)
         state_nx = KEY_IDLE;
      else if (sel)
         state_nx = (wr_data == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= KEY_IDLE;
      else        state <= state_nx;
   end

   // R3: a wrong byte while armed drops the detector back to idle
   assert_break_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == KEY_ARMED && sel && !block && wr_data != KEY_FIRST) |=> state == KEY_IDLE);
   // R9: during the pulse the detector cannot arm
   assert_block_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      block |=> state == KEY_IDLE);
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
   parameter int CNT_W = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic key_hit,
   output logic running,
   output logic ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;

   always_comb ovf = running && tick && !key_hit && (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (key_hit) begin
         running <= 1'b1;
         cnt     <= '0;
      end else if (ovf) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (running && tick) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assert_enable_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(key_hit));
   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && !key_hit && !ovf) |=> cnt == $past(cnt) + CNT_W'(1));
   assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !tick && !key_hit) |=> $stable(cnt));
   assert_no_sw_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(ovf));
   assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> (running && cnt == '0));
endmodule

// File: rtl/wdk_rstout.sv
module wdk_rstout #(
   parameter int PULSE_LEN = 98
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic rst_out
);
   generate
      if (PULSE_LEN == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= fire;
         end
         always_comb rst_out = q;
      end else begin : g_counted
         localparam int PW = $clog2(PULSE_LEN + 1);
         logic [PW-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            left <= '0;
            else if (fire)         left <= PW'(PULSE_LEN);
            else if (left != '0)   left <= left - PW'(1);
         end
         always_comb rst_out = (left != '0);
      end
   endgenerate

   assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rst_out);
   assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out) |-> $past(fire));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int CNT_W = 14,
   parameter int PULSE_LEN = 98,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
   parameter logic [ADDR_W-1:0] AUX_ADDR = 8'h8E,
   parameter logic [DATA_W-1:0] KEY_FIRST = 8'h1E,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1,
   parameter int MASK_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rst_out
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("PULSE_LEN must be at least 1");
   end
   if (MASK_BIT < 0 || MASK_BIT >= DATA_W) begin : g_bad_mask
      $error("MASK_BIT outside data word");
   end
   if (KEY_FIRST == KEY_SECOND) begin : g_bad_key
      $error("key bytes must differ");
   end
   if (KEY_ADDR == AUX_ADDR) begin : g_bad_addr
      $error("addresses must differ");
   end

   logic key_hit, running, ovf, fire, pulse_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pulse_mask <= 1'b0;
      else if (wr_en && wr_addr == AUX_ADDR)
         pulse_mask <= wr_data[MASK_BIT];
   end

   always_comb fire = ovf && !pulse_mask;

   wdk_key_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
      .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
   ) u_key (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .block(rst_out), .key_hit(key_hit)
   );

   wdk_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick), .key_hit(key_hit),
      .running(running), .ovf(ovf)
   );

   wdk_rstout #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .rst_out(rst_out)
   );

   assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && pulse_mask && !rst_out) |=> !rst_out);
   assert_off_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out |-> !running);
endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/100ps
module keyed_watchdog_test;
   localparam int TB_W = 8;
   localparam int TB_PULSE = 98;
   localparam int SPAN = 2 ** TB_W;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rst_out;
   int         total = 0;
   int         bad = 0;
   int         cyc = 0;

   always #2.5 clk = ~clk;

   keyed_watchdog #(.CNT_W(TB_W), .PULSE_LEN(TB_PULSE)) uut (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rst_out(rst_out)
   );

   // vector: [50:49] write count, [48] expect enable, then three addr/data pairs
   localparam logic [50:0] VEC [8] = '{
      {2'd2, 1'b1, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 8'h00, 8'h00},
      {2'd2, 1'b0, 8'hA6, 8'hE1, 8'hA6, 8'h1E, 8'h00, 8'h00},
      {2'd3, 1'b0, 8'hA6, 8'h1E, 8'hA6, 8'h55, 8'hA6, 8'hE1},
      {2'd3, 1'b1, 8'hA6, 8'h1E, 8'h8E, 8'h00, 8'hA6, 8'hE1},
      {2'd3, 1'b1, 8'hA6, 8'h1E, 8'hA6, 8'h1E, 8'hA6, 8'hE1},
      {2'd2, 1'b0, 8'hA5, 8'h1E, 8'hA5, 8'hE1, 8'h00, 8'h00},
      {2'd1, 1'b0, 8'hA6, 8'h1E, 8'h00, 8'h00, 8'h00, 8'h00},
      {2'd2, 1'b0, 8'hA6, 8'h1E, 8'hA6, 8'hE0, 8'h00, 8'h00}
   };

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         total = total + 1;
         bad = bad + 1;
         $display("FAIL watchdog expired actual=hung expected=done");
         summary();
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; mc_tick = 1'b0; wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic key();
      wr(8'hA6, 8'h1E);
      wr(8'hA6, 8'hE1);
   endtask

   task automatic ticks(input int n);
      mc_tick = 1'b1;
      repeat (n) @(negedge clk);
      mc_tick = 1'b0;
   endtask

   task automatic expect_ovf(input string req);
      ticks(SPAN - 1);
      chk(req, rst_out, 1'b0);
      ticks(1);
      chk(req, rst_out, 1'b1);
   endtask

   task automatic pulse_len(output int len);
      len = 0;
      while (rst_out) begin
         len++;
         @(negedge clk);
      end
   endtask

   initial begin
      int len;
      @(negedge clk);
      chk("R1 rst_out in reset", rst_out, 1'b0);
      do_reset();
      ticks(SPAN + 10);
      chk("R1 disabled after reset", rst_out, 1'b0);

      // R2 / R3 key sequence table
      for (int v = 0; v < 8; v++) begin
         do_reset();
         for (int w = 0; w < int'(VEC[v][50:49]); w++)
            wr(VEC[v][47-16*w -: 8], VEC[v][39-16*w -: 8]);
         if (VEC[v][48]) begin
            expect_ovf("R2 key enables");
            pulse_len(len);
            chk("R7 pulse length", len == TB_PULSE, 1'b1);
         end else begin
            ticks(SPAN + 10);
            chk("R3 bad key ignored", rst_out, 1'b0);
         end
      end

      // R6 restart
      do_reset(); key(); ticks(200); key();
      expect_ovf("R6 restart zeroes count");
      pulse_len(len);

      // R5 no software disable
      do_reset(); key(); ticks(50);
      wr(8'hA6, 8'h00); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h77); wr(8'h8E, 8'h00);
      ticks(SPAN - 51);
      chk("R5 still running", rst_out, 1'b0);
      ticks(1);
      chk("R5 overflow despite writes", rst_out, 1'b1);
      pulse_len(len);
      chk("R7 pulse length after R5", len == TB_PULSE, 1'b1);

      // R9 key during pulse ignored, disabled after pulse
      do_reset(); key(); expect_ovf("R9 setup");
      key();
      chk("R9 pulse continues", rst_out, 1'b1);
      while (rst_out) @(negedge clk);
      ticks(SPAN + 10);
      chk("R9 disabled after pulse", rst_out, 1'b0);
      key(); expect_ovf("R9 fresh key re-enables");
      pulse_len(len);

      // R8 mask bit
      do_reset(); wr(8'h8E, 8'h08); key(); ticks(SPAN);
      chk("R8 masked no pulse", rst_out, 1'b0);
      ticks(SPAN + 10);
      chk("R8 masked overflow disables", rst_out, 1'b0);
      wr(8'h8E, 8'hF7); key();
      expect_ovf("R8 mask clear gives pulse");
      pulse_len(len);

      // R4 sparse ticks
      do_reset(); key();
      for (int i = 0; i < SPAN - 1; i++) begin
         mc_tick = 1'b1; @(negedge clk);
         mc_tick = 1'b0; @(negedge clk); @(negedge clk);
      end
      chk("R4 no overflow before last tick", rst_out, 1'b0);
      repeat (40) @(negedge clk);
      chk("R4 idle clocks do not count", rst_out, 1'b0);
      ticks(1);
      chk("R4 overflow on final tick", rst_out, 1'b1);
      pulse_len(len);

      // R10 hardware reset stops it
      do_reset(); key(); ticks(200);
      do_reset(); ticks(SPAN + 10);
      chk("R10 reset disables", rst_out, 1'b0);

      summary();
   end
endmodule